// File: doc/BRIEF.md
# Chainable Handshake FIFO Buffer

This block is a small first-in-first-out store of 16 words by 4 bits. Words enter on the rising edge of a load clock and leave on the rising edge of a separate unload clock. There are no full or empty flags. Two handshake flags take their place: an input-ready flag that says the store can take another word, and an output-ready flag that says the word on the data outputs is valid. The head word appears on the outputs as soon as output ready rises, with no unload edge needed. Each unload edge then steps to the next word. An active-high output enable drives the data outputs, and when it is low the outputs float. An active-low master reset empties the store at once.

The top module can be built as a chain of `STAGES` cells to give more depth. The link between two cells moves one word per load edge. A cell that sits behind a link keeps one slot free so that it can take a word already in flight, so a chain of m cells holds 15m+1 words. To build wider words, several tops are placed side by side. The input-ready flags of the first rank are ANDed together outside the block, and so are the output-ready flags of the last rank, to form the combined flags. No synchronisation between the two clocks is built in. The user must keep the clocks far enough apart, or derive them from one source.

Top module: `rf_chain_fifo`

## Requirements
- R1: Words leave in the order they were accepted. With `oe` high and `out_rdy` high, `q` equals the oldest stored word.
- R2: `in_rdy` is 1 exactly when the first cell holds fewer than 16 words. A rising `ld_clk` edge while `in_rdy` is 1 stores `d`.
- R3: A chain of m cells accepts 15m+1 words before `in_rdy` falls: 16 for one cell and 31 for two.
- R4: While `rst_n` is 0 the buffer is empty, with `in_rdy` = 1 and `out_rdy` = 0, and no clock edge changes that.
- R5: A rising `ld_clk` edge while `in_rdy` is 0 stores nothing and leaves the stored words unchanged.
- R6: A rising `ul_clk` edge while `out_rdy` is 0 has no effect. A word loaded later is the next word presented.
- R7: `out_rdy` is 1 exactly when the last cell holds a word. The head word is on `q` in the same cycle that `out_rdy` rises.
- R8: With `oe` at 0, all four bits of `q` are high impedance.
- R9: A load edge and an unload edge at the same instant both take effect: one word is added and the oldest word is removed.
- R10: Between cells, one word moves per `ld_clk` edge. A cell behind a link stops taking words once it holds 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_clk | input | 1 | Load clock; also clocks the links between cells |
| ul_clk | input | 1 | Unload clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| oe | input | 1 | Output enable, active high |
| d | input | W | Word to be loaded |
| in_rdy | output | 1 | Buffer can accept a word on the next load edge |
| out_rdy | output | 1 | Valid head word is on `q` |
| q | output | W | Head word, high impedance while `oe` is low |

## Verification
A load edge and an unload edge can arrive at the same instant. When that happens, the occupancy has to stay level while the head word moves on. In a chain, the link move and a new input word also share one load edge. The bench raises both clocks together at random points, including at 0 and 16 words. A queue model decides every edge from the state before the edge, and after each edge the bench compares both flags and the head word against that model.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Words a chain of cells can hold: the first cell keeps its full depth,
  // every cell behind a link gives up one slot to the handshake.
  function automatic int unsigned chain_cap(input int unsigned depth,
                                            input int unsigned stages);
    return depth + (stages - 1) * (depth - 1);
  endfunction

  // Occupancy from a pair of wrap-bit pointers.
  function automatic logic [7:0] fill_of(input logic [7:0] wp,
                                         input logic [7:0] rp);
    return wp - rp;
  endfunction
endpackage

// File: rtl/rf_cell.sv
module rf_cell #(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  parameter int HOLD  = 0,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [W-1:0]  wdat,
  output logic [W-1:0]  rdat,
  output logic          can_take,
  output logic          has_word,
  output logic [PW-1:0] level
);
  localparam int LIMIT = DEPTH - HOLD;

  logic [PW-1:0] wptr, rptr;
  logic [W-1:0]  mem [DEPTH];
  logic          wr_fire, rd_fire;

  assign level    = PW'(rf_pkg::fill_of(8'(wptr), 8'(rptr)));
  assign can_take = level < PW'(LIMIT);
  assign has_word = level != '0;
  assign wr_fire  = wr_req & can_take;
  assign rd_fire  = rd_req & has_word;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n)       wptr <= '0;
    else if (wr_fire) wptr <= wptr + 1'b1;
  end

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[wptr[AW-1:0]] <= wdat;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)       rptr <= '0;
    else if (rd_fire) rptr <= rptr + 1'b1;
  end

  assign rdat = mem[rptr[AW-1:0]];
endmodule

// File: rtl/rf_chain_fifo.sv
module rf_chain_fifo #(
  parameter int W      = 4,
  parameter int DEPTH  = 16,
  parameter int STAGES = 1
) (
  input  logic         ld_clk,
  input  logic         ul_clk,
  input  logic         rst_n,
  input  logic         oe,
  input  logic [W-1:0] d,
  output logic         in_rdy,
  output logic         out_rdy,
  output logic [W-1:0] q
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int LAST = STAGES - 1;

  logic [W-1:0]  sdat [STAGES];
  logic [PW-1:0] lvl  [STAGES];
  logic [STAGES-1:0] take, hasw;
  logic [15:0]   total;   // words held across all cells, for the checker

  for (genvar g = 0; g < STAGES; g++) begin : g_cell
    logic         rc, wq, rq;
    logic [W-1:0] wd;

    if (g == LAST) begin : g_tail
      assign rc = ul_clk;
      assign rq = 1'b1;
    end else begin : g_mid
      assign rc = ld_clk;
      assign rq = take[g+1];
    end

    if (g == 0) begin : g_head
      assign wq = 1'b1;
      assign wd = d;
    end else begin : g_link
      assign wq = hasw[g-1];
      assign wd = sdat[g-1];
    end

    rf_cell #(.W(W), .DEPTH(DEPTH), .HOLD((g == 0) ? 0 : 1)) u_cell (
      .wclk    (ld_clk),
      .rclk    (rc),
      .rst_n   (rst_n),
      .wr_req  (wq),
      .rd_req  (rq),
      .wdat    (wd),
      .rdat    (sdat[g]),
      .can_take(take[g]),
      .has_word(hasw[g]),
      .level   (lvl[g])
    );
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < STAGES; i++) total = total + 16'(lvl[i]);
  end

  assign in_rdy  = take[0];
  assign out_rdy = hasw[LAST];
  assign q       = oe ? sdat[LAST] : 'z;
endmodule

// File: rtl/rf_chain_chk.sv
module rf_chain_chk #(
  parameter int DEPTH  = 16,
  parameter int STAGES = 1
) (
  input logic        ld_clk,
  input logic        ul_clk,
  input logic        rst_n,
  input logic        in_rdy,
  input logic        out_rdy,
  input logic [15:0] total
);
  localparam int CAP = rf_pkg::chain_cap(DEPTH, STAGES);

  a_r3_no_overflow: assert property (@(posedge ld_clk) disable iff (!rst_n)
    total <= 16'(CAP));

  a_r2_ready_low_only_when_full: assert property (@(posedge ld_clk) disable iff (!rst_n)
    !in_rdy |-> total >= 16'(DEPTH));

  a_r5_blocked_load_adds_nothing: assert property (@(posedge ld_clk) disable iff (!rst_n)
    !in_rdy |=> total <= $past(total));

  a_r6_blocked_unload_removes_nothing: assert property (@(posedge ul_clk) disable iff (!rst_n)
    !out_rdy |=> total >= $past(total));

  a_r7_ready_means_stored: assert property (@(posedge ul_clk) disable iff (!rst_n)
    out_rdy |-> total != 16'd0);
endmodule

bind rf_chain_fifo rf_chain_chk #(.DEPTH(DEPTH), .STAGES(STAGES)) u_chk (
  .ld_clk (ld_clk),
  .ul_clk (ul_clk),
  .rst_n  (rst_n),
  .in_rdy (in_rdy),
  .out_rdy(out_rdy),
  .total  (total)
);

// File: tb/rf_chain_fifo_test.sv
module rf_chain_fifo_test;
  localparam int CLK_PERIOD = 10;

  logic       ld_clk = 0, ul_clk = 0, rst_n = 1, oe = 1;
  logic [3:0] d = '0;
  wire        in_rdy, out_rdy, in_rdy2, out_rdy2;
  wire  [3:0] q, q2;

  rf_chain_fifo #(.W(4), .DEPTH(16), .STAGES(1)) uut (
    .ld_clk(ld_clk), .ul_clk(ul_clk), .rst_n(rst_n), .oe(oe), .d(d),
    .in_rdy(in_rdy), .out_rdy(out_rdy), .q(q));

  rf_chain_fifo #(.W(4), .DEPTH(16), .STAGES(2)) uut_chain (
    .ld_clk(ld_clk), .ul_clk(ul_clk), .rst_n(rst_n), .oe(oe), .d(d),
    .in_rdy(in_rdy2), .out_rdy(out_rdy2), .q(q2));

  logic [3:0] m1[$];           // single buffer model
  logic [3:0] ma[$], mb[$];    // chain model: front cell, back cell
  int nchecks = 0, nfail = 0, acc1 = 0, acc2 = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(in_rdy == (m1.size() < 16), "R2", {tag, " in_rdy"}, in_rdy, m1.size() < 16);
    check(out_rdy == (m1.size() > 0), "R7", {tag, " out_rdy"}, out_rdy, m1.size() > 0);
    if (oe && m1.size() > 0)
      check(q === m1[0], "R1", {tag, " head"}, q, m1[0]);
    check(in_rdy2 == (ma.size() < 16), "R10", {tag, " chain in_rdy"}, in_rdy2, ma.size() < 16);
    check(out_rdy2 == (mb.size() > 0), "R10", {tag, " chain out_rdy"}, out_rdy2, mb.size() > 0);
    if (oe && mb.size() > 0)
      check(q2 === mb[0], "R1", {tag, " chain head"}, q2, mb[0]);
  endtask

  // One clock slot: inputs settle, chosen clocks rise together, then compare.
  task automatic step(input bit ld, input bit ul, input logic [3:0] din, input string tag);
    bit in1, out1, ina, lnk, outb;
    d = din;
    #1;
    in1  = m1.size() < 16;
    out1 = m1.size() > 0;
    ina  = ma.size() < 16;
    lnk  = ma.size() > 0 && mb.size() < 15;
    outb = mb.size() > 0;
    if (ld && in_rdy)  acc1++;
    if (ld && in_rdy2) acc2++;
    ld_clk = ld;
    ul_clk = ul;
    #5;
    ld_clk = 0;
    ul_clk = 0;
    if (rst_n) begin
      if (ul && out1) void'(m1.pop_front());
      if (ld && in1)  m1.push_back(din);
      if (ul && outb) void'(mb.pop_front());
      if (ld && lnk)  mb.push_back(ma.pop_front());
      if (ld && ina)  ma.push_back(din);
    end
    #2;
    compare(tag);
    #2;
  endtask

  task automatic do_reset(input string tag);
    rst_n = 0;
    m1.delete(); ma.delete(); mb.delete();
    step(1, 1, 4'h9, tag);   // edges during reset must be ignored
    check(in_rdy && in_rdy2, "R4", {tag, " in_rdy in reset"}, in_rdy, 1);
    check(!out_rdy && !out_rdy2, "R4", {tag, " out_rdy in reset"}, out_rdy, 0);
    rst_n = 1;
    #CLK_PERIOD;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchecks++;
    nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    int a1, a2;
    #1;
    do_reset("R4 power-up");

    // Fill both builds; count accepted loads at the ports (R2, R3)
    acc1 = 0; acc2 = 0;
    for (int i = 0; i < 35; i++) step(1, 0, 4'(i), "R3 fill");
    check(acc1 == 16, "R3", "single accepted words", acc1, 16);
    check(acc2 == 31, "R3", "chain accepted words", acc2, 31);
    check(!in_rdy && !in_rdy2, "R2", "in_rdy low when full", in_rdy, 0);

    // Loads while full are ignored (R5)
    a1 = acc1; a2 = acc2;
    for (int i = 0; i < 4; i++) step(1, 0, 4'hF, "R5 blocked load");
    check(acc1 == a1 && acc2 == a2, "R5", "no load taken while full", acc1 - a1, 0);
    check(q === 4'h0, "R5", "oldest word intact", q, 0);

    // Drain with unload only; single empties, chain back cell empties (R1, R10)
    for (int i = 0; i < 20; i++) step(0, 1, 4'h0, "R1 drain");
    check(!out_rdy, "R7", "out_rdy low when empty", out_rdy, 0);

    // Unloads on empty are ignored, then a load is presented at once (R6, R7)
    for (int i = 0; i < 3; i++) step(0, 1, 4'h0, "R6 empty unload");
    step(1, 0, 4'h7, "R6 load after empty");
    check(out_rdy && q === 4'h7, "R6", "word after empty unloads", q, 7);
    step(0, 1, 4'h0, "R6 take");
    check(!out_rdy, "R6", "one word then empty", out_rdy, 0);

    // Both edges together near the limits and mid-range (R9)
    do_reset("R4 before mix");
    for (int i = 0; i < 16; i++) step(1, 0, 4'(i + 3), "R9 prefill");
    step(1, 1, 4'hC, "R9 full both");
    step(1, 1, 4'hD, "R9 full both again");
    for (int i = 0; i < 400; i++) begin
      bit l, u;
      l = ($urandom % 4) != 0;
      u = ($urandom % 4) != 0;
      step(l, u, 4'($urandom), (l && u) ? "R9 both edges" : "R9 mixed");
    end

    // Output enable low floats the bus (R8)
    step(1, 0, 4'h5, "R8 load");
    oe = 0;
    #1;
    check(q === 4'bzzzz, "R8", "single q floating", q, 0);
    check(q2 === 4'bzzzz, "R8", "chain q floating", q2, 0);
    step(1, 1, 4'h6, "R8 edges with oe low");
    check(q === 4'bzzzz, "R8", "single q still floating", q, 0);
    oe = 1;
    step(0, 0, 4'h0, "R8 oe back");

    // Reset with data stored empties everything (R4)
    do_reset("R4 mid-run");
    step(0, 1, 4'h0, "R4 after reset");
    step(1, 0, 4'hA, "R2 load after reset");
    check(out_rdy && q === 4'hA, "R7", "head shown on rise", q, 4'hA);

    finish_run();
  end
endmodule